// File: doc/BRIEF.md
# Main Clock Stop/Restart Supervisor

This block runs entirely from a free-running on-chip reference oscillator. It watches an external main clock and decides when that clock has stopped and when it has started again. A main-clock rising edge flips a toggle flop. The toggle is resynchronized into the reference domain, and every change seen there counts as activity. If no activity arrives for a programmable number of reference cycles, the main clock is declared stopped. It is declared running again after a programmable run of consecutive edges.

A mode input selects how a detected event is handled. In reset mode, the event sets a system-reset output, and that output stays set until the hardware reset input is applied. In interrupt mode, the event produces a one-cycle interrupt request and sets a sticky detection flag. On a stop, the block also moves the CPU clock-source select over to the on-chip oscillator. It does this only when the CPU is fed directly by the main clock, and never when the CPU runs from the PLL. The select output drives an external glitch-free clock multiplexer. A small register port lets software read the flags, clear the sticky flag and write the select bit.

Top module: `clk_loss_monitor`

## Requirements
- R1: After hardware reset, `irq_req`, `sys_rst` and `clk_sel` are 0, and all three read bits are 0. Read bits: bit 0 is the select, bit 1 is the sticky flag, bit 2 is the stopped flag.
- R2: The stopped flag (read bit 2) becomes 1 after `TIMEOUT_CYC` reference cycles pass with no main-clock activity. It does not become 1 earlier. It returns to 0 after `RESTART_EDGES` consecutive main-clock edges.
- R3: In interrupt mode (`irq_mode`=1), a stop produces exactly one `irq_req` pulse lasting one reference cycle. It sets the sticky flag to 1 and does not assert `sys_rst`.
- R4: In interrupt mode with `cpu_src_pll`=0, a stop forces `clk_sel` to 1 (on-chip oscillator).
- R5: In interrupt mode with `cpu_src_pll`=1, a stop leaves `clk_sel` unchanged.
- R6: In interrupt mode, a restart produces exactly one `irq_req` pulse and sets the sticky flag to 1. It clears the stopped flag and leaves `clk_sel` unchanged.
- R7: In reset mode (`irq_mode`=0), a stop sets `sys_rst` with no `irq_req`. `sys_rst` then stays 1 until `hw_rst` is applied, even if the main clock resumes.
- R8: In reset mode, a restart of the main clock also sets `sys_rst`.
- R9: With `det_en`=0, losing the main clock changes no flag, produces no `irq_req` and does not assert `sys_rst`.
- R10: Only a register write with write bit 1 = 0 clears the sticky flag. A write with bit 1 = 1 has no effect on it. A detection event in the same cycle as a clearing write leaves the flag at 1.
- R11: A register write loads write bit 0 into `clk_sel`. An automatic set in the same cycle as a write of 0 wins, and `clk_sel` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running on-chip reference clock |
| hw_rst | input | 1 | Hardware reset, synchronous, active high |
| main_clk | input | 1 | Monitored main clock |
| det_en | input | 1 | Detection enable |
| irq_mode | input | 1 | 0: stop/restart forces reset; 1: interrupt |
| cpu_src_pll | input | 1 | 0: CPU runs directly from main clock; 1: from PLL |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 2 | Bit 0: select value; bit 1: 0 clears sticky flag |
| reg_rdata | output | 3 | Bit 0 select, bit 1 sticky flag, bit 2 stopped flag |
| clk_sel | output | 1 | CPU clock-source select (1 = on-chip oscillator) |
| irq_req | output | 1 | One-cycle interrupt request |
| sys_rst | output | 1 | Latched system reset request |

## Verification
The bench gates the main clock off and on. It does this for both CPU-source settings, and for both modes. One test enables reset mode only after a stop has already happened; a design that treats restart as harmless would miss the reset there. A design that declares a stop too early fails the early-sample check. One that switches the select while the CPU runs from the PLL fails the PLL vectors. Software writes are placed in the exact cycle of an automatic update. There, a design that lets the write win would show a cleared select or sticky flag. A disabled-detection run catches a design that still updates the flags or raises a reset.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
  localparam int WR_W       = 2;
  localparam int RD_W       = 3;
  localparam int SEL_BIT    = 0;
  localparam int STICKY_BIT = 1;
  localparam int STOP_BIT   = 2;

  typedef enum logic {
    DET_RUN  = 1'b0,
    DET_STOP = 1'b1
  } det_state_e;
endpackage

// File: rtl/mcm_sync.sv
module mcm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mcm_detector.sv
module mcm_detector
  import mcm_pkg::*;
#(
  parameter int TIMEOUT_CYC   = 8,
  parameter int RESTART_EDGES = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic ref_clk,
  input  logic hw_rst,
  input  logic main_clk,
  input  logic en,
  output logic stopped,
  output logic lost_evt,
  output logic restart_evt
);
  localparam int IW = $clog2(TIMEOUT_CYC + 1);
  localparam int EW = $clog2(RESTART_EDGES + 1);
  localparam logic [IW-1:0] IDLE_LAST = IW'(TIMEOUT_CYC - 1);
  localparam logic [EW-1:0] EDGE_LAST = EW'(RESTART_EDGES - 1);

  logic       main_tog;
  logic       tog_sync;
  logic       tog_prev;
  logic       activity;
  det_state_e state;
  logic [IW-1:0] idle_cnt;
  logic [EW-1:0] edge_cnt;

  // Divide-by-two in the monitored domain so only level changes cross over.
  always_ff @(posedge main_clk) begin
    if (hw_rst) main_tog <= 1'b0;
    else        main_tog <= ~main_tog;
  end

  mcm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (ref_clk),
    .rst (hw_rst),
    .d   (main_tog),
    .q   (tog_sync)
  );

  always_ff @(posedge ref_clk) begin
    if (hw_rst) tog_prev <= 1'b0;
    else        tog_prev <= tog_sync;
  end

  assign activity = tog_sync ^ tog_prev;

  always_ff @(posedge ref_clk) begin
    if (hw_rst) begin
      state       <= DET_RUN;
      idle_cnt    <= '0;
      edge_cnt    <= '0;
      lost_evt    <= 1'b0;
      restart_evt <= 1'b0;
    end else begin
      lost_evt    <= 1'b0;
      restart_evt <= 1'b0;
      if (en) begin
        case (state)
          DET_RUN: begin
            if (activity) begin
              idle_cnt <= '0;
            end else if (idle_cnt == IDLE_LAST) begin
              state    <= DET_STOP;
              lost_evt <= 1'b1;
              idle_cnt <= '0;
              edge_cnt <= '0;
            end else begin
              idle_cnt <= idle_cnt + 1'b1;
            end
          end
          DET_STOP: begin
            if (activity) begin
              idle_cnt <= '0;
              if (edge_cnt == EDGE_LAST) begin
                state       <= DET_RUN;
                restart_evt <= 1'b1;
                edge_cnt    <= '0;
              end else begin
                edge_cnt <= edge_cnt + 1'b1;
              end
            end else if (idle_cnt == IDLE_LAST) begin
              // gap too long: edge run is not consecutive any more
              idle_cnt <= '0;
              edge_cnt <= '0;
            end else begin
              idle_cnt <= idle_cnt + 1'b1;
            end
          end
          default: state <= DET_RUN;
        endcase
      end
    end
  end

  assign stopped = (state == DET_STOP);
endmodule

// File: rtl/mcm_ctrl.sv
module mcm_ctrl
  import mcm_pkg::*;
(
  input  logic            ref_clk,
  input  logic            hw_rst,
  input  logic            det_en,
  input  logic            irq_mode,
  input  logic            cpu_src_pll,
  input  logic            lost_evt,
  input  logic            restart_evt,
  input  logic            reg_wr,
  input  logic [WR_W-1:0] reg_wdata,
  output logic            clk_sel,
  output logic            sticky,
  output logic            irq_req,
  output logic            sys_rst
);
  logic any_evt;
  logic irq_evt;
  logic rst_evt;
  logic auto_sel;

  assign any_evt  = det_en & (lost_evt | restart_evt);
  assign irq_evt  = any_evt & irq_mode;
  assign rst_evt  = any_evt & ~irq_mode;
  assign auto_sel = det_en & irq_mode & lost_evt & ~cpu_src_pll;

  always_ff @(posedge ref_clk) begin
    if (hw_rst) begin
      clk_sel <= 1'b0;
      sticky  <= 1'b0;
      irq_req <= 1'b0;
      sys_rst <= 1'b0;
    end else begin
      irq_req <= irq_evt;
      if (rst_evt) sys_rst <= 1'b1;
      if (irq_evt)
        sticky <= 1'b1;
      else if (reg_wr && !reg_wdata[STICKY_BIT])
        sticky <= 1'b0;
      if (auto_sel)
        clk_sel <= 1'b1;
      else if (reg_wr)
        clk_sel <= reg_wdata[SEL_BIT];
    end
  end
endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor
  import mcm_pkg::*;
#(
  parameter int TIMEOUT_CYC   = 8,
  parameter int RESTART_EDGES = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic            ref_clk,
  input  logic            hw_rst,
  input  logic            main_clk,
  input  logic            det_en,
  input  logic            irq_mode,
  input  logic            cpu_src_pll,
  input  logic            reg_wr,
  input  logic [WR_W-1:0] reg_wdata,
  output logic [RD_W-1:0] reg_rdata,
  output logic            clk_sel,
  output logic            irq_req,
  output logic            sys_rst
);
  logic stopped;
  logic lost_evt;
  logic restart_evt;
  logic sticky;

  mcm_detector #(
    .TIMEOUT_CYC   (TIMEOUT_CYC),
    .RESTART_EDGES (RESTART_EDGES),
    .SYNC_STAGES   (SYNC_STAGES)
  ) u_det (
    .ref_clk     (ref_clk),
    .hw_rst      (hw_rst),
    .main_clk    (main_clk),
    .en          (det_en),
    .stopped     (stopped),
    .lost_evt    (lost_evt),
    .restart_evt (restart_evt)
  );

  mcm_ctrl u_ctrl (
    .ref_clk     (ref_clk),
    .hw_rst      (hw_rst),
    .det_en      (det_en),
    .irq_mode    (irq_mode),
    .cpu_src_pll (cpu_src_pll),
    .lost_evt    (lost_evt),
    .restart_evt (restart_evt),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .clk_sel     (clk_sel),
    .sticky      (sticky),
    .irq_req     (irq_req),
    .sys_rst     (sys_rst)
  );

  always_comb begin
    reg_rdata             = '0;
    reg_rdata[SEL_BIT]    = clk_sel;
    reg_rdata[STICKY_BIT] = sticky;
    reg_rdata[STOP_BIT]   = stopped;
  end
endmodule

// File: rtl/mcm_checker.sv
module mcm_checker
  import mcm_pkg::*;
(
  input logic            ref_clk,
  input logic            hw_rst,
  input logic            det_en,
  input logic            irq_mode,
  input logic            cpu_src_pll,
  input logic            reg_wr,
  input logic [WR_W-1:0] reg_wdata,
  input logic [RD_W-1:0] reg_rdata,
  input logic            clk_sel,
  input logic            irq_req,
  input logic            sys_rst
);
  assert_irq_single_cycle_R3: assert property (@(posedge ref_clk) disable iff (hw_rst)
    irq_req |=> !irq_req);

  assert_irq_only_in_irq_mode_R3: assert property (@(posedge ref_clk) disable iff (hw_rst)
    irq_req |-> $past(irq_mode));

  assert_rst_held_R7: assert property (@(posedge ref_clk) disable iff (hw_rst)
    sys_rst |=> sys_rst);

  assert_rst_only_in_rst_mode_R7: assert property (@(posedge ref_clk) disable iff (hw_rst)
    $rose(sys_rst) |-> (!$past(irq_mode) && $past(det_en)));

  assert_no_irq_when_disabled_R9: assert property (@(posedge ref_clk) disable iff (hw_rst)
    !det_en |=> !irq_req);

  assert_stop_flag_needs_enable_R9: assert property (@(posedge ref_clk) disable iff (hw_rst)
    $rose(reg_rdata[STOP_BIT]) |-> $past(det_en));

  assert_auto_sel_direct_only_R5: assert property (@(posedge ref_clk) disable iff (hw_rst)
    ($rose(clk_sel) && !$past(reg_wr)) |-> ($past(irq_mode) && !$past(cpu_src_pll)));

  assert_sticky_clear_by_write_R10: assert property (@(posedge ref_clk) disable iff (hw_rst)
    $fell(reg_rdata[STICKY_BIT]) |-> ($past(reg_wr) && !$past(reg_wdata[STICKY_BIT])));

  assert_sel_clear_by_write_R11: assert property (@(posedge ref_clk) disable iff (hw_rst)
    $fell(reg_rdata[SEL_BIT]) |-> ($past(reg_wr) && !$past(reg_wdata[SEL_BIT])));
endmodule

bind clk_loss_monitor mcm_checker u_chk (.*);

// File: tb/clk_loss_monitor_test.sv
module clk_loss_monitor_test;
  localparam int TIMEOUT_CYC = 8;

  logic       ref_clk = 1'b0;
  logic       main_clk = 1'b0;
  logic       main_gate;
  logic       hw_rst;
  logic       det_en;
  logic       irq_mode;
  logic       cpu_src_pll;
  logic       reg_wr;
  logic [1:0] reg_wdata;
  logic [2:0] reg_rdata;
  logic       clk_sel;
  logic       irq_req;
  logic       sys_rst;

  int n_cmp = 0;
  int n_bad = 0;
  int irq_cnt = 0;
  bit done = 0;

  clk_loss_monitor #(.TIMEOUT_CYC(TIMEOUT_CYC)) uut (
    .ref_clk     (ref_clk),
    .hw_rst      (hw_rst),
    .main_clk    (main_clk),
    .det_en      (det_en),
    .irq_mode    (irq_mode),
    .cpu_src_pll (cpu_src_pll),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .clk_sel     (clk_sel),
    .irq_req     (irq_req),
    .sys_rst     (sys_rst)
  );

  always #5 ref_clk = ~ref_clk;
  initial forever #20 main_clk = main_gate ? ~main_clk : main_clk;

  always @(negedge ref_clk) if (irq_req) irq_cnt++;

  // {clr, mode, pll, gate, stopped, sticky, sel, irq[1:0], rst}
  localparam logic [9:0] VEC [5] = '{
    10'b0_1_0_0_1_1_1_01_0,
    10'b0_1_0_1_0_1_1_01_0,
    10'b1_1_1_0_1_1_0_01_0,
    10'b1_1_1_1_0_1_0_01_0,
    10'b1_1_0_1_0_0_0_00_0
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic wr(input logic [1:0] d);
    reg_wr = 1'b1;
    reg_wdata = d;
    @(negedge ref_clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_hw_rst();
    hw_rst = 1'b1;
    wait_cyc(6);
    hw_rst = 1'b0;
    wait_cyc(2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge ref_clk);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int irq0;
    main_gate = 1'b1; hw_rst = 1'b1; det_en = 1'b1; irq_mode = 1'b1;
    cpu_src_pll = 1'b0; reg_wr = 1'b0; reg_wdata = 2'b00;
    wait_cyc(6);
    hw_rst = 1'b0;
    wait_cyc(20);
    chk("R1", "rdata", int'(reg_rdata), 0);
    chk("R1", "irq_req", int'(irq_req), 0);
    chk("R1", "sys_rst", int'(sys_rst), 0);
    chk("R1", "clk_sel", int'(clk_sel), 0);

    // table-driven interrupt-mode vectors
    for (int i = 0; i < 5; i++) begin
      logic [9:0] v;
      v = VEC[i];
      if (v[9]) wr(2'b00);
      irq_mode = v[8];
      cpu_src_pll = v[7];
      irq0 = irq_cnt;
      main_gate = v[6];
      if (!v[6] && v[5]) begin
        wait_cyc(5);
        chk("R2", "stopped too early", int'(reg_rdata[2]), 0);
        wait_cyc(55);
      end else begin
        wait_cyc(60);
      end
      chk("R2", "stopped flag", int'(reg_rdata[2]), int'(v[5]));
      chk("R3/R6", "sticky flag", int'(reg_rdata[1]), int'(v[4]));
      chk("R4/R5", "clk_sel", int'(clk_sel), int'(v[3]));
      chk("R3/R6", "irq pulses", irq_cnt - irq0, int'(v[2:1]));
      chk("R3", "sys_rst", int'(sys_rst), int'(v[0]));
    end

    // same-cycle write against automatic set (R10, R11)
    wr(2'b00);
    cpu_src_pll = 1'b0;
    main_gate = 1'b0;
    for (int k = 0; k < 100 && !reg_rdata[2]; k++) @(negedge ref_clk);
    wr(2'b00);
    chk("R11", "auto set beats write", int'(clk_sel), 1);
    chk("R10", "event beats clear", int'(reg_rdata[1]), 1);
    wr(2'b10);
    chk("R10", "write 1 keeps sticky", int'(reg_rdata[1]), 1);
    chk("R11", "sw write sel 0", int'(clk_sel), 0);
    wr(2'b01);
    chk("R10", "write 0 clears sticky", int'(reg_rdata[1]), 0);
    chk("R11", "sw write sel 1", int'(clk_sel), 1);
    wr(2'b00);
    main_gate = 1'b1;
    wait_cyc(60);

    // reset mode: stop latches reset (R7)
    irq_mode = 1'b0;
    irq0 = irq_cnt;
    main_gate = 1'b0;
    wait_cyc(40);
    chk("R7", "sys_rst on stop", int'(sys_rst), 1);
    chk("R7", "no irq", irq_cnt - irq0, 0);
    main_gate = 1'b1;
    wait_cyc(60);
    chk("R7", "sys_rst still held", int'(sys_rst), 1);
    pulse_hw_rst();
    chk("R7", "sys_rst cleared by hw_rst", int'(sys_rst), 0);
    chk("R1", "rdata after hw_rst", int'(reg_rdata), 0);

    // reset mode: restart also latches reset (R8)
    irq_mode = 1'b1;
    main_gate = 1'b0;
    wait_cyc(40);
    chk("R8", "stopped before mode change", int'(reg_rdata[2]), 1);
    irq_mode = 1'b0;
    main_gate = 1'b1;
    wait_cyc(60);
    chk("R8", "sys_rst on restart", int'(sys_rst), 1);
    irq_mode = 1'b1;
    pulse_hw_rst();

    // detection disabled (R9)
    det_en = 1'b0;
    irq0 = irq_cnt;
    main_gate = 1'b0;
    wait_cyc(40);
    chk("R9", "stopped unchanged", int'(reg_rdata[2]), 0);
    chk("R9", "sticky unchanged", int'(reg_rdata[1]), 0);
    chk("R9", "no sys_rst", int'(sys_rst), 0);
    chk("R9", "no irq", irq_cnt - irq0, 0);
    main_gate = 1'b1;
    wait_cyc(20);
    det_en = 1'b1;
    wait_cyc(30);
    chk("R9", "quiet after re-enable", irq_cnt - irq0, 0);
    chk("R9", "clk_sel unchanged", int'(clk_sel), 0);

    finish_run();
  end
endmodule